// File: doc/BRIEF.md
# Serial Speech Block Aligner and Deframer

The block sits on the receive side of an 8 kbit/s speech circuit. The circuit arrives one bit at a time with a qualifying strobe. When the call handler raises `search_en`, the block hunts for the block marker. The marker is a run of at least 24 zeros closed by a one. After the marker the block locks onto a fixed 480-bit grid and re-checks the marker at every predicted block start. Each complete block yields two 137-bit speech frames and five control bits. It also reports whether any of the interleaved guard ones arrived corrupted.

When the marker is missing at its predicted place, the block drops out of lock and hunts again at once. The downstream speech decoder still needs a steady cadence of blocks. So while a call is active but unaligned, the block emits a substitute block. The substitute reports both frames as normal traffic with errors, so the decoder conceals them. A substitute is emitted at the moment of the loss and then once every 480 bit periods until lock returns.

Positions are counted within a block from 0, where position 24 is the one that closes the marker. Positions 0 to 23 are the marker zeros.

Top module: `circuit_block_deframer`

## Requirements
- R1: While `search_en` is high, the block locks on the first one that follows at least 24 consecutive zeros. `in_sync_o` rises on the clock edge that samples that one.
- R2: While `search_en` is low, the block neither hunts nor tracks. `in_sync_o` reads 0 from the next edge on, and no block strobe is produced for any input pattern.
- R3: When locked, `blk_vld_o` pulses for one cycle on the edge that samples block position 479. `ctrl_o` then carries the bits received at positions 25 to 29, the first of them in `ctrl_o[4]`.
- R4: The first frame takes the first 137 non-guard bits from position 30 onward. The second frame takes the first 137 non-guard bits from position 247 onward. In each frame the earliest bit lands in bit 136.
- R5: Every position that is a multiple of 24 from 48 to 456 is a guard and must hold a one. `blk_err_o` reads 1 with a block in which any guard held a zero, and 0 otherwise. A guard error does not break lock.
- R6: When locked, a one at positions 0 to 23 or a zero at position 24 breaks lock. On the edge that samples that bit, `in_sync_o` falls. On the same edge a substitute block is strobed on `blk_vld_o` with `ctrl_o` = 5'b00011 (stealing code 000, both error flags 1).
- R7: While the call is active and lock is lost, a further substitute block, with the same `ctrl_o` value, is strobed on every 480th bit after the previous one.
- R8: After a loss, lock returns at the next one that follows at least 24 zeros. The block that this marker opens is delivered normally.
- R9: Bits outside the marker, the control field, the guards and the two frames may take any value. They change neither the frames, nor `ctrl_o`, nor `blk_err_o`.
- R10: `in_sync_o` and `blk_err_o` both read 0 whenever the block is not locked, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_en | input | 1 | Call active: hunt and track while high |
| bit_vld | input | 1 | Qualifies `bit_in` for one cycle per circuit bit |
| bit_in | input | 1 | Serial circuit bit |
| frame_a_o | output | 137 | First speech frame of the last delivered block |
| frame_b_o | output | 137 | Second speech frame of the last delivered block |
| ctrl_o | output | 5 | Control field of the last delivered or substitute block |
| blk_vld_o | output | 1 | One-cycle strobe per delivered or substitute block |
| blk_err_o | output | 1 | Guard error in the last delivered block (locked only) |
| in_sync_o | output | 1 | Block alignment held |

## Verification
The assertions take for granted that `search_en` changes only between circuit bits, never in the same cycle as a `bit_vld` strobe. They also assume the control field never reads the substitute code while a normal block ends exactly as the call drops. The stimulus raises and lowers `search_en` only while the bit strobe is idle. Bits are strobed every other clock, so a strobe never lands next to a search-enable change. Substitute-block checks are made only while the call stays active.

// File: rtl/cbd_pkg.sv
`timescale 1ns/1ps
package cbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2,
    ST_LOST = 2'd3
  } trk_state_e;
endpackage

// File: rtl/cbd_marker_det.sv
`timescale 1ns/1ps
// Counts consecutive zeros (saturating) and flags a one that closes a long enough run.
module cbd_marker_det #(
  parameter int HDR_ZEROS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic marker_o
);
  localparam int RW = $clog2(HDR_ZEROS + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(HDR_ZEROS);

  logic [RW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (bit_vld) begin
      if (bit_in)                run_d = '0;
      else if (run_q != RUN_FULL) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign marker_o = bit_vld & bit_in & (run_q == RUN_FULL);
endmodule

// File: rtl/cbd_tracker.sv
`timescale 1ns/1ps
// Alignment state machine: hunt, lock, per-block marker re-check, loss cadence, guard check.
module cbd_tracker import cbd_pkg::*; #(
  parameter int BLK_BITS  = 480,
  parameter int HDR_ZEROS = 24,
  parameter int PW        = $clog2(BLK_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          search_en,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic          marker_i,
  output trk_state_e    state_o,
  output logic [PW-1:0] pos_o,
  output logic          blk_end_o,
  output logic          synth_o,
  output logic          guard_err_o
);
  localparam logic [PW-1:0] LAST  = PW'(BLK_BITS - 1);
  localparam logic [PW-1:0] HDR   = PW'(HDR_ZEROS);
  localparam logic [PW-1:0] FIRST = PW'(HDR_ZEROS + 1);

  trk_state_e    state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [PW-1:0] lcnt_q, lcnt_d;
  logic          gerr_q, gerr_d;
  logic          hdr_bad, is_guard;

  assign hdr_bad  = (pos_q < HDR) ? bit_in : ((pos_q == HDR) ? ~bit_in : 1'b0);
  assign is_guard = (pos_q > HDR) && ((pos_q % HDR) == '0);

  always_comb begin
    state_d   = state_q;
    pos_d     = pos_q;
    lcnt_d    = lcnt_q;
    gerr_d    = gerr_q;
    blk_end_o = 1'b0;
    synth_o   = 1'b0;
    if (!search_en) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_HUNT;
        ST_HUNT: begin
          if (bit_vld && marker_i) begin
            state_d = ST_LOCK;
            pos_d   = FIRST;
            gerr_d  = 1'b0;
          end
        end
        ST_LOCK: begin
          if (bit_vld) begin
            if (hdr_bad) begin
              state_d = ST_LOST;
              synth_o = 1'b1;
              lcnt_d  = '0;
            end else begin
              pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
              if (pos_q == HDR)         gerr_d = 1'b0;
              if (is_guard && !bit_in) gerr_d = 1'b1;
              if (pos_q == LAST)       blk_end_o = 1'b1;
            end
          end
        end
        ST_LOST: begin
          if (bit_vld) begin
            if (marker_i) begin
              state_d = ST_LOCK;
              pos_d   = FIRST;
              gerr_d  = 1'b0;
            end else if (lcnt_q == LAST) begin
              synth_o = 1'b1;
              lcnt_d  = '0;
            end else begin
              lcnt_d = lcnt_q + 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      lcnt_q  <= '0;
      gerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      lcnt_q  <= lcnt_d;
      gerr_q  <= gerr_d;
    end
  end

  assign state_o     = state_q;
  assign pos_o       = pos_q;
  assign guard_err_o = gerr_q;

  AST_IDLE_WITHOUT_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> state_q == ST_IDLE); // R2
  AST_HDR_MISS_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (search_en && state_q == ST_LOCK && bit_vld && pos_q < HDR && bit_in) |=> state_q == ST_LOST); // R6
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST); // R3
endmodule

// File: rtl/cbd_sb_capture.sv
`timescale 1ns/1ps
// Shifts one frame's data bits in from a fixed start position, skipping guard positions.
module cbd_sb_capture #(
  parameter int BLK_BITS   = 480,
  parameter int HDR_ZEROS  = 24,
  parameter int FRAME_BITS = 137,
  parameter int START      = 30,
  parameter int PW         = $clog2(BLK_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_vld,
  input  logic                  bit_in,
  input  logic                  locked,
  input  logic [PW-1:0]         pos,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] FULL   = CW'(FRAME_BITS);
  localparam logic [PW-1:0] STARTP = PW'(START);
  localparam logic [PW-1:0] HDR    = PW'(HDR_ZEROS);
  localparam logic [PW-1:0] LAST   = PW'(BLK_BITS - 1);

  logic [CW-1:0]         cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  at_start, running, is_guard, take;

  assign at_start = (pos == STARTP);
  assign running  = (cnt_q != '0) && (cnt_q != FULL);
  assign is_guard = (pos > HDR) && ((pos % HDR) == '0);
  assign take     = locked & bit_vld & ~is_guard & (at_start | running);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (take) begin
      sh_d  = {sh_q[FRAME_BITS-2:0], bit_in};
      cnt_d = at_start ? CW'(1) : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign frame_o = sh_q;

  AST_FRAME_FULL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bit_vld && pos == LAST) |-> cnt_q == FULL); // R4
endmodule

// File: rtl/circuit_block_deframer.sv
`timescale 1ns/1ps
module circuit_block_deframer import cbd_pkg::*; #(
  parameter int BLK_BITS   = 480,
  parameter int HDR_ZEROS  = 24,
  parameter int CTRL_BITS  = 5,
  parameter int FRAME_BITS = 137,
  parameter int SB1_START  = 30,
  parameter int SB2_START  = 247
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  search_en,
  input  logic                  bit_vld,
  input  logic                  bit_in,
  output logic [FRAME_BITS-1:0] frame_a_o,
  output logic [FRAME_BITS-1:0] frame_b_o,
  output logic [CTRL_BITS-1:0]  ctrl_o,
  output logic                  blk_vld_o,
  output logic                  blk_err_o,
  output logic                  in_sync_o
);
  localparam int PW = $clog2(BLK_BITS);
  localparam int NSUB = 2;
  localparam logic [PW-1:0] CPOS = PW'(HDR_ZEROS + 1);
  localparam logic [PW-1:0] CEND = PW'(HDR_ZEROS + CTRL_BITS);
  localparam logic [CTRL_BITS-1:0] SYNTH_CTRL = CTRL_BITS'(2'b11);

  logic          marker;
  trk_state_e    state;
  logic [PW-1:0] pos;
  logic          blk_end, synth, guard_err, locked;
  logic [FRAME_BITS-1:0] cap [NSUB];

  cbd_marker_det #(.HDR_ZEROS(HDR_ZEROS)) u_marker (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .marker_o(marker)
  );

  cbd_tracker #(.BLK_BITS(BLK_BITS), .HDR_ZEROS(HDR_ZEROS), .PW(PW)) u_trk (
    .clk(clk), .rst_n(rst_n), .search_en(search_en), .bit_vld(bit_vld), .bit_in(bit_in),
    .marker_i(marker), .state_o(state), .pos_o(pos), .blk_end_o(blk_end),
    .synth_o(synth), .guard_err_o(guard_err)
  );

  assign locked = (state == ST_LOCK);

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    localparam int ST = (g == 0) ? SB1_START : SB2_START;
    cbd_sb_capture #(
      .BLK_BITS(BLK_BITS), .HDR_ZEROS(HDR_ZEROS), .FRAME_BITS(FRAME_BITS),
      .START(ST), .PW(PW)
    ) u_cap (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .locked(locked), .pos(pos), .frame_o(cap[g])
    );
  end

  // control field shift and output hold registers
  logic [CTRL_BITS-1:0]  csh_q, csh_d, ctrl_q, ctrl_d;
  logic [FRAME_BITS-1:0] fa_q, fa_d, fb_q, fb_d;
  logic                  vld_q, vld_d, err_q, err_d;

  always_comb begin
    csh_d  = csh_q;
    ctrl_d = ctrl_q;
    fa_d   = fa_q;
    fb_d   = fb_q;
    err_d  = err_q;
    vld_d  = blk_end | synth;
    if (locked && bit_vld && pos >= CPOS && pos <= CEND)
      csh_d = {csh_q[CTRL_BITS-2:0], bit_in};
    if (blk_end) begin
      ctrl_d = csh_q;
      err_d  = guard_err;
      fa_d   = cap[0];
      fb_d   = cap[1];
    end else if (synth) begin
      ctrl_d = SYNTH_CTRL;
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csh_q  <= '0;
      ctrl_q <= '0;
      fa_q   <= '0;
      fb_q   <= '0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      csh_q  <= csh_d;
      ctrl_q <= ctrl_d;
      fa_q   <= fa_d;
      fb_q   <= fb_d;
      err_q  <= err_d;
      vld_q  <= vld_d;
    end
  end

  assign frame_a_o = fa_q;
  assign frame_b_o = fb_q;
  assign ctrl_o    = ctrl_q;
  assign blk_vld_o = vld_q;
  assign in_sync_o = locked;
  assign blk_err_o = err_q & locked;

  AST_LOCK_ON_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync_o) |-> $past(marker)); // R1
  AST_SYNTH_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_vld_o && !in_sync_o && $past(search_en)) |-> ctrl_o == SYNTH_CTRL); // R6
endmodule

// File: tb/circuit_block_deframer_tb.sv
`timescale 1ns/1ps
module circuit_block_deframer_tb;
  localparam int NB = 480;
  localparam int FB = 137;
  localparam logic [4:0] SYN = 5'b00011;

  logic clk, rst_n, search_en, bit_vld, bit_in;
  logic [FB-1:0] frame_a_o, frame_b_o;
  logic [4:0] ctrl_o;
  logic blk_vld_o, blk_err_o, in_sync_o;

  int checks = 0, fails = 0, n_vld = 0;
  logic [4:0] m_ctrl;
  logic m_err, m_sync;
  logic [FB-1:0] m_fa, m_fb;

  circuit_block_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .search_en(search_en), .bit_vld(bit_vld), .bit_in(bit_in),
    .frame_a_o(frame_a_o), .frame_b_o(frame_b_o), .ctrl_o(ctrl_o),
    .blk_vld_o(blk_vld_o), .blk_err_o(blk_err_o), .in_sync_o(in_sync_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (blk_vld_o) begin
      n_vld++;
      m_ctrl = ctrl_o; m_err = blk_err_o; m_sync = in_sync_o;
      m_fa = frame_a_o; m_fb = frame_b_o;
    end
  end

  task automatic chk(input string req, input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] pat(input logic [31:0] s);
    logic [159:0] t;
    t = {5{s}};
    return t[FB-1:0];
  endfunction

  function automatic logic [NB-1:0] mk_blk(input logic [4:0] c, input logic [FB-1:0] a,
                                           input logic [FB-1:0] b, input logic spare);
    logic [NB-1:0] v;
    int k, p;
    for (int i = 0; i < NB; i++) v[i] = spare;
    for (int i = 0; i < 24; i++) v[i] = 1'b0;
    v[24] = 1'b1;
    for (int i = 0; i < 5; i++) v[25+i] = c[4-i];
    for (int i = 48; i <= 456; i += 24) v[i] = 1'b1;
    k = 0; p = 30;
    while (k < FB) begin
      if (p % 24 != 0) begin v[p] = a[FB-1-k]; k++; end
      p++;
    end
    k = 0; p = 247;
    while (k < FB) begin
      if (p % 24 != 0) begin v[p] = b[FB-1-k]; k++; end
      p++;
    end
    return v;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b; bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    #1;
  endtask

  task automatic send_range(input logic [NB-1:0] v, input int lo, input int hi);
    for (int p = lo; p <= hi; p++) send_bit(v[p]);
  endtask

  task automatic chk_block(input string req, input logic [4:0] c, input logic [FB-1:0] a,
                           input logic [FB-1:0] b, input logic e);
    chk({req, " ctrl"}, FB'(m_ctrl), FB'(c));
    chk({req, " frame_a"}, m_fa, a);
    chk({req, " frame_b"}, m_fb, b);
    chk({req, " err"}, FB'(m_err), FB'(e));
  endtask

  // R10: reset state
  task automatic t_reset();
    chk("R10 in_sync after reset", FB'(in_sync_o), '0);
    chk("R10 blk_err after reset", FB'(blk_err_o), '0);
    chk("R3 blk_vld after reset", FB'(blk_vld_o), '0);
  endtask

  // R2: no search while search_en low
  task automatic t_idle();
    int v0 = n_vld;
    send_range(mk_blk(5'b01010, pat(32'h0F0F_1234), pat(32'h5555_AAAA), 1'b1), 0, NB-1);
    chk("R2 no lock while idle", FB'(in_sync_o), '0);
    chk("R2 no block while idle", FB'(n_vld - v0), '0);
  endtask

  // R1, R3, R4: first lock and delivery
  task automatic t_lock();
    logic [NB-1:0] v;
    int v0;
    logic [FB-1:0] a = pat(32'hA5C3_1E77), b = pat(32'h3C96_D00B);
    v = mk_blk(5'b01001, a, b, 1'b1);
    search_en = 1'b1;
    for (int i = 0; i < 30; i++) send_bit(1'b1);
    chk("R1 no lock on ones", FB'(in_sync_o), '0);
    v0 = n_vld;
    send_range(v, 0, 23);
    chk("R1 no lock before closing one", FB'(in_sync_o), '0);
    send_range(v, 24, 24);
    chk("R1 lock on closing one", FB'(in_sync_o), FB'(1));
    send_range(v, 25, NB-2);
    chk("R3 no strobe before last bit", FB'(n_vld - v0), '0);
    send_range(v, NB-1, NB-1);
    chk("R3 one strobe at last bit", FB'(n_vld - v0), FB'(1));
    chk_block("R3 R4 first block", 5'b01001, a, b, 1'b0);
  endtask

  // R9: spares all zero, new data
  task automatic t_spare();
    int v0 = n_vld;
    logic [FB-1:0] a = pat(32'h1234_5678), b = pat(32'hFEDC_0193);
    send_range(mk_blk(5'b10110, a, b, 1'b0), 0, NB-1);
    chk("R9 strobe", FB'(n_vld - v0), FB'(1));
    chk_block("R9 spares ignored", 5'b10110, a, b, 1'b0);
  endtask

  // R5: guard error then clean block
  task automatic t_guard();
    logic [NB-1:0] v;
    logic [FB-1:0] a = pat(32'h0BAD_F00D), b = pat(32'h7777_1111);
    v = mk_blk(5'b00100, a, b, 1'b1);
    v[240] = 1'b0;
    send_range(v, 0, NB-1);
    chk_block("R5 guard error", 5'b00100, a, b, 1'b1);
    chk("R5 lock kept", FB'(in_sync_o), FB'(1));
    send_range(mk_blk(5'b00100, a, b, 1'b1), 0, NB-1);
    chk("R5 clean block", FB'(m_err), '0);
  endtask

  // R6, R8: one extra bit, re-lock on same block
  task automatic t_slip_plus();
    int v0 = n_vld;
    logic [FB-1:0] a = pat(32'hC0DE_2468), b = pat(32'h1357_9BDF);
    send_bit(1'b1);
    chk("R6 substitute strobe", FB'(n_vld - v0), FB'(1));
    chk("R6 substitute ctrl", FB'(m_ctrl), FB'(SYN));
    chk("R6 in_sync drops", FB'(in_sync_o), '0);
    chk("R10 err low while lost", FB'(m_err), '0);
    send_range(mk_blk(5'b11000, a, b, 1'b1), 0, NB-1);
    chk("R8 relock strobe", FB'(n_vld - v0), FB'(2));
    chk_block("R8 relock block", 5'b11000, a, b, 1'b0);
    chk("R8 in_sync back", FB'(in_sync_o), FB'(1));
  endtask

  // R6, R7, R8: one missing bit, loss cadence, re-lock
  task automatic t_slip_minus();
    int v0 = n_vld;
    logic [FB-1:0] a = pat(32'h2222_9999), b = pat(32'hABCD_EF01);
    logic [NB-1:0] v = mk_blk(5'b00111, a, b, 1'b1);
    send_range(v, 1, 24);
    chk("R6 loss on early one", FB'(n_vld - v0), FB'(1));
    chk("R6 substitute ctrl", FB'(m_ctrl), FB'(SYN));
    send_range(v, 25, NB-1);
    chk("R8 no block while lost", FB'(n_vld - v0), FB'(1));
    chk("R10 in_sync low while lost", FB'(in_sync_o), '0);
    for (int i = 0; i < 200; i++) send_bit(1'b1);
    chk("R7 periodic substitute", FB'(n_vld - v0), FB'(2));
    chk("R7 periodic ctrl", FB'(m_ctrl), FB'(SYN));
    chk("R10 blk_err low while lost", FB'(blk_err_o), '0);
    a = pat(32'h4444_0F0F); b = pat(32'h8080_7F7F);
    send_range(mk_blk(5'b01100, a, b, 1'b1), 0, NB-1);
    chk("R8 relock after loss", FB'(n_vld - v0), FB'(3));
    chk_block("R8 relocked block", 5'b01100, a, b, 1'b0);
  endtask

  // R2: dropping search_en ends tracking
  task automatic t_search_off();
    int v0;
    search_en = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R2 in_sync off with call", FB'(in_sync_o), '0);
    v0 = n_vld;
    send_range(mk_blk(5'b00001, pat(32'h1), pat(32'h2), 1'b1), 0, NB-1);
    chk("R2 no strobe after call", FB'(n_vld - v0), '0);
  endtask

  initial begin
    rst_n = 1'b0; search_en = 1'b0; bit_vld = 1'b0; bit_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_idle();
    t_lock();
    t_spare();
    t_guard();
    t_slip_plus();
    t_slip_minus();
    t_search_off();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule